// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable stand-in for a small three-wire serial EEPROM. The clock, data-in and select lines are sampled on the system clock, and the block acts on each rising edge of the serial clock. It decodes a start bit, a two-bit opcode and an address. It keeps a write-enable latch. It serves single and streaming reads. It runs a self-timed erase or program cycle whose length is counted in system clocks. Storage is a small register array of bytes that reset fills with ones.

An organization input selects the access width. High gives 16-bit words with `AW16` address bits. Low gives bytes with `AW16+1` address bits. The serial output is driven only while select is high and the block has something to say: the dummy zero and the data stream of a read, the busy level of a running cycle, or the ready level after a cycle has finished. A reset input stands in for the power-on reset.

Top module: `mw_eeprom`

## Requirements
- R1: After reset every byte of the array reads as 0xFF, the write-enable latch is clear and `do_oe` is low.
- R2: With `cs` high, serial clock rises that sample `di` at 0 before the first 1 are ignored. The first 1 sampled is the start bit.
- R3: After the start bit, two opcode bits are shifted in, then the address MSB first. The address is `AW16` bits wide when `org_x16`=1 and `AW16+1` bits wide when `org_x16`=0. The opcodes are: 10 read, 01 write, 11 erase. Opcode 00 is decoded by the two most significant address bits: 11 enables writes, 00 disables writes, 10 erases the whole array, 01 writes one value to the whole array.
- R4: While the write-enable latch is clear, write, erase, erase-all and write-all leave the array unchanged and start no busy cycle. Read works whatever the latch holds.
- R5: A read drives a 0 after the rise that samples the last address bit. Each later rise then shifts out one data bit, MSB first. While `cs` stays high, the next location follows with no extra 0, and the address wraps from the last location to 0.
- R6: A write takes 16 data bits (`org_x16`=1) or 8 data bits (`org_x16`=0), MSB first, after the address. When the cycle completes, it stores them at the addressed word or byte, replacing the old content.
- R7: Erase sets the addressed word or byte to all ones. Erase-all sets every byte to 0xFF. Write-all stores the supplied value at every address.
- R8: A programming cycle starts only if `cs` falls after the last expected bit and before any further serial clock rise. One extra rise cancels the instruction.
- R9: A cycle lasts `PROG_CYCLES` system clocks from the fall of `cs`. While it runs, `cs` high gives `do_oe`=1 and `do_o`=0, and serial input is ignored.
- R10: After a cycle completes, `cs` high gives `do_oe`=1 and `do_o`=1. This lasts until `cs` falls or a start bit is sampled.
- R11: `do_oe` is low whenever `cs` is low and while an instruction is being shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, stands in for power-on reset |
| org_x16 | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, acted on at its rising edge |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out: read data or ready/busy level |
| do_oe | output | 1 | Output enable for `do_o` |

## Verification
The bench writes a distinct computed pattern to every word in 16-bit mode and to every byte in 8-bit mode. It then streams the whole array back past its end, so a wrong address increment, a wrong byte order or a missing wrap gives a mismatch at a known location. Fill patterns from erase-all and write-all check that every location is hit. Rejected instructions (latch clear, one extra clock) and leading zeros are each followed by a read of the target, which separates "ignored" from "executed". The ready/busy checks place `cs` high during the cycle, after the cycle with `cs` low, and across a new start bit, which separates the three ways the ready level can end.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_DATA  = 3'd2,
        ST_READ  = 3'd3,
        ST_ARMED = 3'd4,
        ST_HOLD  = 3'd5,
        ST_BUSY  = 3'd6
    } mw_state_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_ERASE = 2'd1,
        OP_ERAL  = 2'd2,
        OP_WRAL  = 2'd3
    } mw_op_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_ERASE = 2'b11;
    localparam logic [1:0] OPC_EXT   = 2'b00;

    localparam logic [1:0] EXT_WEN  = 2'b11;
    localparam logic [1:0] EXT_WDS  = 2'b00;
    localparam logic [1:0] EXT_ERAL = 2'b10;
    localparam logic [1:0] EXT_WRAL = 2'b01;

endpackage

// File: rtl/mw_edge.sv
module mw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    input  logic cs,
    output logic sk_rise,
    output logic cs_fall
);
    logic sk_q;
    logic cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sk;
            cs_q <= cs;
        end
    end

    assign sk_rise = sk & ~sk_q;
    assign cs_fall = cs_q & ~cs;
endmodule

// File: rtl/mw_store.sv
module mw_store #(
    parameter int AW8 = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_fill,
    input  logic           wr_x16,
    input  logic [AW8-1:0] wr_addr,
    input  logic [15:0]    wr_data,
    input  logic           rd_x16,
    input  logic [AW8-1:0] rd_addr,
    output logic [15:0]    rd_word
);
    localparam int NB = 1 << AW8;

    logic [7:0] mem_q [NB];

    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam logic [AW8-1:0] IDX = AW8'(i);
        logic hit;
        logic [7:0] val;

        always_comb begin
            hit = wr_fill || (wr_x16 ? (IDX[AW8-1:1] == wr_addr[AW8-2:0])
                                     : (IDX == wr_addr));
            val = (wr_x16 && !IDX[0]) ? wr_data[15:8] : wr_data[7:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            mem_q[i] <= 8'hFF;
            else if (wr_en && hit) mem_q[i] <= val;
        end
    end

    logic [AW8-1:0] hi_idx;
    logic [AW8-1:0] lo_idx;

    always_comb begin
        hi_idx  = {rd_addr[AW8-2:0], 1'b0};
        lo_idx  = {rd_addr[AW8-2:0], 1'b1};
        rd_word = rd_x16 ? {mem_q[hi_idx], mem_q[lo_idx]} : {mem_q[rd_addr], 8'h00};
    end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int AW16        = 4,
    parameter int PROG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic org_x16,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_o,
    output logic do_oe
);
    localparam int AW8   = AW16 + 1;
    localparam int HDR_W = AW8 + 2;
    localparam int CNT_W = $clog2(HDR_W + 17);
    localparam int TMR_W = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        mw_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [HDR_W-1:0] hdr;
        logic [15:0]      dat;
        logic [AW8-1:0]   addr;
        mw_op_e           op;
        logic             wel;
        logic             rdy;
        logic             q;
        logic [TMR_W-1:0] tmr;
    } ctl_t;

    ctl_t r_q, r_d;

    logic sk_rise, cs_fall;
    logic commit;
    logic [15:0] rd_word;

    mw_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sk      (sk),
        .cs      (cs),
        .sk_rise (sk_rise),
        .cs_fall (cs_fall)
    );

    mw_store #(.AW8(AW8)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_fill (r_q.op == OP_ERAL || r_q.op == OP_WRAL),
        .wr_x16  (org_x16),
        .wr_addr (r_q.addr),
        .wr_data (r_q.dat),
        .rd_x16  (org_x16),
        .rd_addr (r_q.addr),
        .rd_word (rd_word)
    );

    logic [CNT_W-1:0] hdr_len, word_len, cnt_inc;
    logic [HDR_W-1:0] hdr_nx;
    logic [1:0]       opc, ext;
    logic [AW8-1:0]   addr_nx, addr_inc;

    always_comb begin
        r_d      = r_q;
        commit   = 1'b0;
        hdr_len  = org_x16 ? CNT_W'(AW16 + 2) : CNT_W'(AW8 + 2);
        word_len = org_x16 ? CNT_W'(16) : CNT_W'(8);
        cnt_inc  = r_q.cnt + 1'b1;
        hdr_nx   = {r_q.hdr[HDR_W-2:0], di};
        opc      = org_x16 ? hdr_nx[AW16+1 -: 2] : hdr_nx[AW8+1 -: 2];
        ext      = org_x16 ? hdr_nx[AW16-1 -: 2] : hdr_nx[AW8-1 -: 2];
        addr_nx  = org_x16 ? {1'b0, hdr_nx[AW16-1:0]} : hdr_nx[AW8-1:0];
        addr_inc = org_x16 ? {1'b0, r_q.addr[AW16-1:0] + AW16'(1)} : r_q.addr + 1'b1;

        if (cs_fall) r_d.rdy = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (cs && sk_rise && di) begin
                    r_d.st  = ST_CMD;
                    r_d.cnt = '0;
                    r_d.hdr = '0;
                    r_d.rdy = 1'b0;
                end
            end
            ST_CMD: begin
                if (sk_rise) begin
                    r_d.hdr = hdr_nx;
                    r_d.cnt = cnt_inc;
                    if (cnt_inc == hdr_len) begin
                        r_d.addr = addr_nx;
                        r_d.cnt  = '0;
                        r_d.dat  = 16'hFFFF;
                        unique case (opc)
                            OPC_READ: begin
                                r_d.st = ST_READ;
                                r_d.q  = 1'b0;
                            end
                            OPC_WRITE: begin
                                r_d.st = ST_DATA;
                                r_d.op = OP_WRITE;
                            end
                            OPC_ERASE: begin
                                r_d.st = ST_ARMED;
                                r_d.op = OP_ERASE;
                            end
                            default: begin
                                unique case (ext)
                                    EXT_WEN:  begin r_d.wel = 1'b1; r_d.st = ST_HOLD; end
                                    EXT_WDS:  begin r_d.wel = 1'b0; r_d.st = ST_HOLD; end
                                    EXT_ERAL: begin r_d.op = OP_ERAL; r_d.st = ST_ARMED; end
                                    default:  begin r_d.op = OP_WRAL; r_d.st = ST_DATA; end
                                endcase
                            end
                        endcase
                    end
                end
            end
            ST_DATA: begin
                if (sk_rise) begin
                    r_d.dat = {r_q.dat[14:0], di};
                    r_d.cnt = cnt_inc;
                    if (cnt_inc == word_len) r_d.st = ST_ARMED;
                end
            end
            ST_READ: begin
                if (sk_rise) begin
                    if (r_q.cnt == '0) begin
                        r_d.q   = rd_word[15];
                        r_d.dat = {rd_word[14:0], 1'b0};
                        r_d.cnt = word_len - 1'b1;
                    end else begin
                        r_d.q   = r_q.dat[15];
                        r_d.dat = {r_q.dat[14:0], 1'b0};
                        r_d.cnt = r_q.cnt - 1'b1;
                        if (r_q.cnt == CNT_W'(1)) r_d.addr = addr_inc;
                    end
                end
            end
            ST_ARMED: begin
                if (!cs) begin
                    if (r_q.wel) begin
                        r_d.st  = ST_BUSY;
                        r_d.tmr = TMR_W'(PROG_CYCLES - 1);
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end else if (sk_rise) begin
                    r_d.st = ST_HOLD;
                end
            end
            ST_BUSY: begin
                if (r_q.tmr == '0) begin
                    commit  = 1'b1;
                    r_d.st  = ST_IDLE;
                    r_d.rdy = 1'b1;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            default: ;
        endcase

        if (!cs && (r_q.st == ST_CMD || r_q.st == ST_DATA ||
                    r_q.st == ST_READ || r_q.st == ST_HOLD))
            r_d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign do_oe = cs && (r_q.st == ST_READ || r_q.st == ST_BUSY ||
                          (r_q.st == ST_IDLE && r_q.rdy));
    assign do_o  = (r_q.st == ST_READ) ? r_q.q : (r_q.st != ST_BUSY);
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs,
    input logic      sk_rise,
    input logic      do_o,
    input logic      do_oe,
    input mw_state_e st,
    input logic      tmr_zero,
    input logic      wel,
    input logic      commit
);
    a_r11_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !do_oe);

    a_r9_busy_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && cs) |-> (do_oe && !do_o));

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && !tmr_zero) |=> (st == ST_BUSY));

    a_r10_ready_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && tmr_zero) |=> (st == ST_IDLE));

    a_r4_commit_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> wel);

    a_r5_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && $past(st) == ST_CMD) |-> !do_o);

    a_r8_extra_clock_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && cs && sk_rise) |=> (st == ST_HOLD));
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .sk_rise  (sk_rise),
    .do_o     (do_o),
    .do_oe    (do_oe),
    .st       (r_q.st),
    .tmr_zero (r_q.tmr == '0),
    .wel      (r_q.wel),
    .commit   (commit)
);

// File: tb/mw_eeprom_bench.sv
module mw_eeprom_bench;
    localparam int CLK_P = 10;
    localparam int AW16  = 4;
    localparam int PROG  = 40;
    localparam int NB    = 1 << (AW16 + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic org_x16 = 1'b1;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic do_o, do_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0] ref_mem [NB];

    always #(CLK_P/2) clk = ~clk;

    mw_eeprom #(.AW16(AW16), .PROG_CYCLES(PROG)) u_mw_eeprom (
        .clk(clk), .rst_n(rst_n), .org_x16(org_x16),
        .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic s, output logic e);
        di = b;
        tick(2);
        sk = 1'b1;
        tick(3);
        s = do_o;
        e = do_oe;
        sk = 1'b0;
        tick(2);
    endtask

    task automatic cs_hi();
        cs = 1'b1;
        tick(2);
    endtask

    task automatic cs_lo();
        cs = 1'b0;
        sk = 1'b0;
        tick(2);
    endtask

    function automatic int aw();
        return org_x16 ? AW16 : AW16 + 1;
    endfunction

    function automatic int ww();
        return org_x16 ? 16 : 8;
    endfunction

    function automatic int nwords();
        return 1 << aw();
    endfunction

    function automatic int exp_word(input int a);
        int m = a % nwords();
        if (org_x16) return {ref_mem[2*m], ref_mem[2*m+1]};
        return ref_mem[m];
    endfunction

    task automatic send_hdr(input logic [1:0] opc, input int addr,
                            output logic s, output logic e);
        clk_bit(1'b1, s, e);
        clk_bit(opc[1], s, e);
        clk_bit(opc[0], s, e);
        for (int i = aw() - 1; i >= 0; i--) clk_bit(1'((addr >> i) & 1), s, e);
    endtask

    task automatic send_data(input int d);
        logic s, e;
        for (int i = ww() - 1; i >= 0; i--) clk_bit(1'((d >> i) & 1), s, e);
    endtask

    task automatic ext_op(input logic [1:0] code);
        logic s, e;
        cs_hi();
        send_hdr(2'b00, int'(code) << (aw() - 2), s, e);
        cs_lo();
    endtask

    task automatic wait_ready(input string req);
        int cnt = 0;
        cs = 1'b1;
        tick(1);
        chk(do_oe && !do_o, "R9", {req, " busy level"}, {do_oe, do_o}, 2'b10);
        while (!do_o && cnt < 4 * PROG) begin
            tick(1);
            cnt++;
        end
        chk(cnt >= PROG - 3 && cnt <= PROG, "R9", {req, " cycle length"}, cnt, PROG - 2);
        chk(do_oe && do_o, "R10", {req, " ready level"}, {do_oe, do_o}, 2'b11);
        cs_lo();
    endtask

    task automatic write_cmd(input logic [1:0] opc, input int addr, input int d,
                             input bit with_data);
        logic s, e;
        cs_hi();
        send_hdr(opc, addr, s, e);
        if (with_data) send_data(d);
        cs_lo();
    endtask

    task automatic rd_seq(input int start, input int n, input string req);
        logic s, e;
        int got;
        cs_hi();
        send_hdr(2'b10, start, s, e);
        chk(e && !s, "R5", {req, " dummy zero"}, {e, s}, 2'b10);
        for (int k = 0; k < n; k++) begin
            got = 0;
            for (int b = 0; b < ww(); b++) begin
                clk_bit(1'b0, s, e);
                got = (got << 1) | int'(s);
            end
            chk(got == exp_word(start + k), req, $sformatf("read word %0d", start + k),
                got, exp_word(start + k));
        end
        cs_lo();
    endtask

    task automatic no_cycle(input string req);
        cs_hi();
        chk(!do_oe, req, "no cycle started", do_oe, 0);
        cs_lo();
    endtask

    initial begin
        logic s, e;
        int v;
        for (int i = 0; i < NB; i++) ref_mem[i] = 8'hFF;
        tick(4);
        chk(!do_oe, "R1", "oe in reset", do_oe, 0);
        rst_n = 1'b1;
        tick(2);
        chk(!do_oe, "R1", "oe after reset", do_oe, 0);

        // R1 R5: blank array, streamed past its end to show the wrap
        rd_seq(0, nwords() + 2, "R1");

        // R4: write without the enable latch
        write_cmd(2'b01, 3, 16'h1234, 1);
        no_cycle("R4");
        rd_seq(3, 1, "R4");

        // R6 R3: every word in 16-bit mode
        ext_op(2'b11);
        for (int a = 0; a < nwords(); a++) begin
            v = ((a * 16'h0F1D) ^ 16'hC35A) & 16'hFFFF;
            write_cmd(2'b01, a, v, 1);
            wait_ready("R6");
            ref_mem[2*a] = v[15:8];
            ref_mem[2*a+1] = v[7:0];
        end
        rd_seq(0, nwords() + 1, "R6");
        rd_seq(nwords() - 1, 2, "R5");

        // R2: leading zeros ahead of the start bit, oe stays low (R11)
        cs_hi();
        for (int i = 0; i < 3; i++) begin
            clk_bit(1'b0, s, e);
            chk(!e, "R11", "oe during leading zeros", e, 0);
        end
        clk_bit(1'b1, s, e);
        chk(!e, "R11", "oe during command", e, 0);
        clk_bit(1'b1, s, e);
        clk_bit(1'b0, s, e);
        for (int i = aw() - 1; i >= 0; i--) clk_bit(1'((5 >> i) & 1), s, e);
        chk(e && !s, "R2", "dummy after leading zeros", {e, s}, 2'b10);
        v = 0;
        for (int b = 0; b < 16; b++) begin
            clk_bit(1'b0, s, e);
            v = (v << 1) | int'(s);
        end
        chk(v == exp_word(5), "R2", "data after leading zeros", v, exp_word(5));
        cs_lo();
        chk(!do_oe, "R11", "oe with cs low", do_oe, 0);

        // R7: single erase
        write_cmd(2'b11, 7, 0, 0);
        wait_ready("R7");
        ref_mem[14] = 8'hFF;
        ref_mem[15] = 8'hFF;
        rd_seq(6, 3, "R7");

        // R9 R10: bits sent while busy are ignored, start bit clears ready
        write_cmd(2'b01, 2, 16'h0BAD, 1);
        cs = 1'b1;
        tick(2);
        chk(do_oe && !do_o, "R9", "busy with cs high", {do_oe, do_o}, 2'b10);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s, e);
        v = 0;
        while (!do_o && v < 4 * PROG) begin
            tick(1);
            v++;
        end
        chk(do_oe && do_o, "R9", "no command decoded while busy", {do_oe, do_o}, 2'b11);
        clk_bit(1'b1, s, e);
        chk(!e, "R10", "start bit ends ready", e, 0);
        cs_lo();
        ref_mem[4] = 8'h0B;
        ref_mem[5] = 8'hAD;
        rd_seq(2, 1, "R6");

        // R10: cycle ends with cs low, ready shown once
        write_cmd(2'b01, 4, 16'h7E81, 1);
        tick(PROG + 10);
        cs_hi();
        chk(do_oe && do_o, "R10", "ready after idle wait", {do_oe, do_o}, 2'b11);
        cs_lo();
        cs_hi();
        chk(!do_oe, "R10", "ready cleared by cs fall", do_oe, 0);
        cs_lo();
        ref_mem[8] = 8'h7E;
        ref_mem[9] = 8'h81;

        // R8: one extra clock cancels the write
        cs_hi();
        send_hdr(2'b01, 9, s, e);
        send_data(16'h0000);
        clk_bit(1'b0, s, e);
        cs_lo();
        no_cycle("R8");
        rd_seq(8, 2, "R8");

        // R7: write-all
        cs_hi();
        send_hdr(2'b00, 1 << (aw() - 2), s, e);
        send_data(16'h5AA5);
        cs_lo();
        wait_ready("R7");
        for (int i = 0; i < NB; i++) ref_mem[i] = i[0] ? 8'hA5 : 8'h5A;
        rd_seq(0, nwords() + 1, "R7");

        // R4: erase-all rejected after disable, read still works
        ext_op(2'b00);
        write_cmd(2'b00, 2 << (aw() - 2), 0, 0);
        no_cycle("R4");
        rd_seq(11, 1, "R4");

        // R3 R6: byte organization, every byte
        org_x16 = 1'b0;
        tick(2);
        ext_op(2'b11);
        for (int a = 0; a < NB; a++) begin
            v = (a * 37 + 8'h3C) & 8'hFF;
            write_cmd(2'b01, a, v, 1);
            wait_ready("R3");
            ref_mem[a] = v[7:0];
        end
        rd_seq(0, NB + 2, "R3");

        // R7: erase-all in byte mode, read back as words
        write_cmd(2'b00, 2 << (aw() - 2), 0, 0);
        wait_ready("R7");
        for (int i = 0; i < NB; i++) ref_mem[i] = 8'hFF;
        org_x16 = 1'b1;
        tick(2);
        rd_seq(0, nwords(), "R7");

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule